// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked system and an external asynchronous static RAM of 256K bytes. A system agent raises a request with an address, a write flag and write data; the controller takes it only while it is idle, and then plays out a fixed strobe sequence on the memory pins. Each sequence has four phases: select, access, hold or turnaround, and return to idle. A one-cycle ready pulse tells the agent that read data has been captured or that the write has finished.

The length of every phase comes from nanosecond limits. The controller converts each limit to a whole number of clock cycles, using a clock-period parameter and a speed-grade parameter. Writes are framed by the write strobe alone, with both chip enables held active across the pulse. After a read, the controller waits out the window in which the memory may still drive the data pins. Only then can a later write drive the bus. When idle, the memory is deselected and the controller releases the data bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and while idle, the chip enables are inactive (`mem_ce1_n`=1, `mem_ce2`=0), `mem_oe_n`=1, `mem_we_n`=1, `sys_ready`=0 and the data bus is released. The outputs stay this way for as long as `sys_req` is low.
- R2: A request is accepted only in the idle state. Address, write flag and write data are sampled in the accepting cycle, and later changes to these inputs have no effect on the access in progress. Acceptance is seen on the memory pins one cycle later, when the chip becomes selected.
- R3: A read (`sys_we`=0) selects the chip with `mem_oe_n`=0 and `mem_we_n`=1 for 1+RD_CYC cycles. The data on the bus is registered into `sys_rdata` at the end of the last of those cycles, before the output enable is released.
- R4: A write (`sys_we`=1) selects the chip with `mem_oe_n`=1 and `mem_we_n`=1 for one setup cycle. It then holds `mem_we_n`=0 for exactly WR_CYC cycles, with the address and the driven data unchanged.
- R5: After a write pulse, `mem_we_n` returns high for a one-cycle recovery phase. The enables, address and data are held through this phase, and the block then returns to idle.
- R6: After a read, the chip is deselected with output enable high for TA_CYC cycles before idle. The controller does not drive the data bus until at least TA_CYC cycles after the output enable rose.
- R7: `sys_ready` is a single-cycle pulse in the cycle after the last access cycle. `sys_rdata` keeps the last read value until the next read completes.
- R8: Phase lengths are derived as RD_CYC = ceil(access_ns/CLK_PERIOD_NS), WR_CYC = ceil(max(addr-to-end, pulse, data-setup)/CLK_PERIOD_NS) and TA_CYC = ceil(release_ns/CLK_PERIOD_NS), each at least 1. The fast grade uses 70/70/35 ns and the slow grade uses 100/100/40 ns.
- R9: The output enable is never low while the write strobe is low, and a write strobe only occurs with both enables active.
- R10: The memory address changes only while the write strobe is high and was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_req | input | 1 | Request present |
| sys_we | input | 1 | 1 = write, 0 = read |
| sys_addr | input | 18 | Word address |
| sys_wdata | input | 8 | Write data |
| sys_ready | output | 1 | One-cycle completion pulse |
| sys_rdata | output | 8 | Last read data |
| mem_addr | output | 18 | Memory address pins |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
The bench builds the controller with a 5 ns clock period and the fast grade. Under those values the read window is 14 cycles, the write pulse is 14 cycles and the read turnaround is 7 cycles. The bench checks each exact latency and each exact gap between requests against these numbers. A cycle-level memory model returns wrong data if the read window is too short. It also counts any write whose pulse, data setup or address window falls below the fast-grade limits, and any write select that begins while the model could still be driving the bus. Back-to-back read-after-write and write-after-read pairs bring both turnaround paths within reach.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    localparam int SRAM_AW = 18;
    localparam int SRAM_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    typedef struct packed {
        int unsigned access_ns;   // address/select to valid data
        int unsigned write_ns;    // longest write-side window
        int unsigned release_ns;  // output release to high impedance
        int unsigned recover_ns;  // write recovery
    } grade_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic grade_t grade_timing(bit fast);
        grade_t g;
        if (fast) begin
            g.access_ns  = 70;
            g.write_ns   = max3(70, 35, 30);
            g.release_ns = 35;
        end else begin
            g.access_ns  = 100;
            g.write_ns   = max3(100, 50, 40);
            g.release_ns = 40;
        end
        g.recover_ns = 0;
        return g;
    endfunction

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
        int unsigned q;
        q = (ns + period - 1) / period;
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC  = 14,
    parameter int WR_CYC  = 14,
    parameter int TA_CYC  = 7,
    parameter int REC_CYC = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sys_req,
    input  logic    sys_we,
    output logic    accept,
    output logic    capture,
    output logic    ready,
    output strobe_t strobe
);
    localparam int MAX_AB = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_CD = (TA_CYC > REC_CYC) ? TA_CYC : REC_CYC;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_C) + 1;

    seq_state_e       state, nxt;
    logic             op_wr, wr_next;
    logic             load, t_done, fin;
    logic [CNT_W-1:0] lval;
    strobe_t          strobe_q, s_nxt;
    logic             ready_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (lval),
        .done     (t_done)
    );

    always_comb begin
        nxt     = state;
        load    = 1'b0;
        lval    = '0;
        accept  = 1'b0;
        capture = 1'b0;
        fin     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (sys_req) begin
                    accept = 1'b1;
                    nxt    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                nxt  = ST_ACCESS;
                load = 1'b1;
                lval = op_wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
            end
            ST_ACCESS: begin
                if (t_done) begin
                    fin     = 1'b1;
                    capture = ~op_wr;
                    nxt     = ST_HOLD;
                    load    = 1'b1;
                    lval    = op_wr ? CNT_W'(REC_CYC - 1) : CNT_W'(TA_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (t_done)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign wr_next = accept ? sys_we : op_wr;

    always_comb begin
        s_nxt = STROBE_OFF;
        case (nxt)
            ST_SETUP: begin
                s_nxt.ce1_n = 1'b0;
                s_nxt.ce2   = 1'b1;
                s_nxt.oe_n  = wr_next;
                s_nxt.drive = wr_next;
            end
            ST_ACCESS: begin
                s_nxt.ce1_n = 1'b0;
                s_nxt.ce2   = 1'b1;
                s_nxt.oe_n  = wr_next;
                s_nxt.we_n  = ~wr_next;
                s_nxt.drive = wr_next;
            end
            ST_HOLD: begin
                if (wr_next) begin
                    s_nxt.ce1_n = 1'b0;
                    s_nxt.ce2   = 1'b1;
                    s_nxt.drive = 1'b1;
                end
            end
            default: s_nxt = STROBE_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_wr    <= 1'b0;
            strobe_q <= STROBE_OFF;
            ready_q  <= 1'b0;
        end else begin
            state    <= nxt;
            op_wr    <= wr_next;
            strobe_q <= s_nxt;
            ready_q  <= fin;
        end
    end

    assign strobe = strobe_q;
    assign ready  = ready_q;
endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
    parameter int AW = 18,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            wdata    <= '0;
            rdata    <= '0;
        end else begin
            if (accept) begin
                mem_addr <= in_addr;
                wdata    <= in_wdata;
            end
            if (capture)
                rdata <= bus_in;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = SRAM_AW,
    parameter int DATA_W        = SRAM_DW,
    parameter int CLK_PERIOD_NS = 5,
    parameter bit FAST_GRADE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_req,
    input  logic              sys_we,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic [DATA_W-1:0] sys_wdata,
    output logic              sys_ready,
    output logic [DATA_W-1:0] sys_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam grade_t TIM     = grade_timing(FAST_GRADE);
    localparam int     RD_CYC  = int'(ns_to_cycles(TIM.access_ns,  CLK_PERIOD_NS));
    localparam int     WR_CYC  = int'(ns_to_cycles(TIM.write_ns,   CLK_PERIOD_NS));
    localparam int     TA_CYC  = int'(ns_to_cycles(TIM.release_ns, CLK_PERIOD_NS));
    localparam int     REC_CYC = int'(ns_to_cycles(TIM.recover_ns, CLK_PERIOD_NS));

    logic              accept, capture;
    strobe_t           strobe;
    logic              dq_drive;
    logic [DATA_W-1:0] wdata;

    sram_seq_fsm #(
        .RD_CYC  (RD_CYC),
        .WR_CYC  (WR_CYC),
        .TA_CYC  (TA_CYC),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sys_req (sys_req),
        .sys_we  (sys_we),
        .accept  (accept),
        .capture (capture),
        .ready   (sys_ready),
        .strobe  (strobe)
    );

    sram_data_path #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .capture  (capture),
        .in_addr  (sys_addr),
        .in_wdata (sys_wdata),
        .bus_in   (mem_dq),
        .mem_addr (mem_addr),
        .wdata    (wdata),
        .rdata    (sys_rdata)
    );

    assign mem_ce1_n = strobe.ce1_n;
    assign mem_ce2   = strobe.ce2;
    assign mem_oe_n  = strobe.oe_n;
    assign mem_we_n  = strobe.we_n;
    assign dq_drive  = strobe.drive;
    assign mem_dq    = dq_drive ? wdata : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
    parameter int RD_CYC = 14,
    parameter int WR_CYC = 14,
    parameter int TA_CYC = 7,
    parameter int AW     = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          sys_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce1_n,
    input logic          mem_ce2,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          dq_drive
);
    localparam int CW  = $clog2(RD_CYC + WR_CYC + TA_CYC + 4) + 1;
    localparam int SAT = TA_CYC + 1;

    logic [CW-1:0] quiet_cnt, oe_low_cnt, we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt  <= CW'(SAT);
            oe_low_cnt <= '0;
            we_low_cnt <= '0;
        end else begin
            if (!mem_oe_n)
                quiet_cnt <= '0;
            else if (quiet_cnt < CW'(SAT))
                quiet_cnt <= quiet_cnt + 1'b1;
            oe_low_cnt <= mem_oe_n ? '0 : oe_low_cnt + 1'b1;
            we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !sys_ready && !dq_drive)); // R1

    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_low_cnt == CW'(RD_CYC + 1))); // R3

    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt == CW'(WR_CYC))); // R4

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> dq_drive); // R4

    AST_RECOVER_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && dq_drive)); // R5

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> (quiet_cnt >= CW'(TA_CYC))); // R6

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sys_ready |=> !sys_ready); // R7

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_ce1_n && mem_ce2)); // R9

    AST_ADDR_UNDER_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n))); // R10
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC),
    .AW     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sys_ready (sys_ready),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .dq_drive  (dq_drive)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
    localparam int P    = 5;
    localparam int T_AA = 70, T_WP = 35, T_DW = 30, T_AW = 70, T_HZ = 35;
    localparam int B_RD = (70 + P - 1) / P;  // 14
    localparam int B_WR = (70 + P - 1) / P;  // 14
    localparam int B_TA = (35 + P - 1) / P;  // 7
    localparam logic [7:0] UNWRITTEN = 8'hC3;

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 18'h00000, 8'h11, 8'h00},
        '{1'b1, 18'h3FFFF, 8'hEE, 8'h00},
        '{1'b0, 18'h00000, 8'h5C, 8'h11},
        '{1'b0, 18'h3FFFF, 8'h00, 8'hEE},
        '{1'b1, 18'h15555, 8'hA5, 8'h00},
        '{1'b1, 18'h15555, 8'h5A, 8'h00},
        '{1'b0, 18'h15555, 8'hFF, 8'h5A},
        '{1'b0, 18'h2AAAA, 8'h00, UNWRITTEN},
        '{1'b1, 18'h00001, 8'h00, 8'h00},
        '{1'b0, 18'h00001, 8'h77, 8'h00},
        '{1'b0, 18'h00000, 8'h00, 8'h11},
        '{1'b0, 18'h3FFFF, 8'h00, 8'hEE}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_req = 1'b0, sys_we = 1'b0;
    logic [17:0] sys_addr = '0;
    logic [7:0]  sys_wdata = '0;
    logic        sys_ready;
    logic [7:0]  sys_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
    wire  [7:0]  mem_dq;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sram_async_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .sys_req   (sys_req),
        .sys_we    (sys_we),
        .sys_addr  (sys_addr),
        .sys_wdata (sys_wdata),
        .sys_ready (sys_ready),
        .sys_rdata (sys_rdata),
        .mem_addr  (mem_addr),
        .mem_ce1_n (mem_ce1_n),
        .mem_ce2   (mem_ce2),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq    (mem_dq)
    );

    // ---------------- behavioural memory model (cycle level) ----------------
    logic [7:0]  mem [int];
    logic        m_drive = 1'b0;
    logic [7:0]  m_data = '0;
    logic [17:0] p_addr = '0;
    logic [7:0]  wdat = '0;
    bit          p_rd = 0, p_wl = 0;
    int          acc = 0, astab = 0, rel = 1000, wlen = 0, dstab = 0;
    int          v_wr = 0, v_bus = 0, v_oe = 0, v_addr = 0;

    assign mem_dq = m_drive ? m_data : 8'bz;

    function automatic logic [7:0] rdmem(logic [17:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : UNWRITTEN;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            m_drive = 1'b0; p_rd = 0; p_wl = 0; rel = 1000; acc = 0; astab = 0;
            p_addr = mem_addr;
        end else begin
            bit sel, rd, wl, achg;
            sel  = !mem_ce1_n && mem_ce2;
            rd   = sel && !mem_oe_n && mem_we_n;
            wl   = !mem_we_n;
            achg = (mem_addr != p_addr);
            if (achg && (wl || p_wl)) v_addr++;
            if (wl && (!sel || !mem_oe_n)) v_oe++;
            acc   = (rd && p_rd && !achg) ? acc + 1 : 1;
            astab = achg ? 1 : astab + 1;
            if (rd) rel = 0; else if (rel < 1000) rel++;
            if (sel && mem_oe_n && rel > 0 && (rel - 1) * P < T_HZ) v_bus++;
            if (wl) begin
                dstab = (p_wl && mem_dq == wdat) ? dstab + 1 : 1;
                wlen  = p_wl ? wlen + 1 : 1;
                wdat  = mem_dq;
            end
            if (p_wl && !wl) begin
                if (wlen * P < T_WP || dstab * P < T_DW || astab * P < T_AW) v_wr++;
                mem[int'(p_addr)] = wdat;
            end
            m_drive = rd;
            m_data  = (acc * P >= T_AA) ? rdmem(mem_addr) : ~rdmem(mem_addr);
            p_rd = rd; p_wl = wl; p_addr = mem_addr;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit idle_pins();
        return mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !sys_ready;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        int gap_exp;
        logic [7:0] last_rd;
        bit idle_ok;
        last_rd = 8'h00;
        repeat (4) @(negedge clk);
        chk(idle_pins(), "R1 reset strobes", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
        rst = 1'b0;
        idle_ok = 1'b1;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (!idle_pins()) idle_ok = 1'b0;
        end
        chk(idle_ok, "R1 idle with no request", idle_ok, 1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            gap_exp = (i == 0) ? 1 : (VEC[i-1].wr ? 2 : B_TA + 1);
            sys_req = 1'b1; sys_we = VEC[i].wr; sys_addr = VEC[i].addr; sys_wdata = VEC[i].data;
            k = 0;
            do begin
                @(negedge clk); k++;
                if (k == 1 && i > 0) chk(!sys_ready, "R7 ready single cycle", sys_ready, 0);
            end while (!(!mem_ce1_n && mem_ce2 && !(VEC[i].wr == 0 && mem_oe_n)) && k < 100);
            // R2, R5, R6: request taken only once idle is reached
            chk(k == gap_exp, (i > 0 && !VEC[i-1].wr) ? "R6 read turnaround gap" : "R2 R5 accept gap", k, gap_exp);
            chk(mem_addr == VEC[i].addr, "R2 address latched", mem_addr, VEC[i].addr);
            chk(mem_we_n && (mem_oe_n == VEC[i].wr), VEC[i].wr ? "R4 write setup pins" : "R3 read setup pins",
                {mem_oe_n, mem_we_n}, {VEC[i].wr, 1'b1});
            // inputs change while busy: must be ignored (R2)
            sys_we = ~VEC[i].wr; sys_addr = ~VEC[i].addr; sys_wdata = ~VEC[i].data;
            k = 0;
            do begin @(negedge clk); k++; end while (!sys_ready && k < 100);
            if (VEC[i].wr) begin
                chk(k == B_WR + 1, "R4 R8 write latency", k, B_WR + 1);
                chk(mem_we_n && !mem_ce1_n && mem_ce2 && mem_oe_n, "R5 recovery pins",
                    {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b0111);
                chk(sys_rdata == last_rd, "R7 rdata held over write", sys_rdata, last_rd);
            end else begin
                chk(k == B_RD + 1, "R3 R8 read latency", k, B_RD + 1);
                chk(sys_rdata == VEC[i].exp, "R3 read data", sys_rdata, VEC[i].exp);
                chk(mem_ce1_n && !mem_ce2 && mem_oe_n, "R6 deselect after read",
                    {mem_ce1_n, mem_ce2, mem_oe_n}, 3'b101);
                last_rd = VEC[i].exp;
            end
        end
        sys_req = 1'b0;

        // directed: return to idle, model-side timing and contention records
        repeat (20) @(negedge clk);
        chk(idle_pins(), "R1 idle after traffic", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
        chk(sys_rdata == last_rd, "R7 rdata held in idle", sys_rdata, last_rd);
        chk(v_wr == 0, "R4 R8 write timing violations", v_wr, 0);
        chk(v_bus == 0, "R6 bus contention", v_bus, 0);
        chk(v_oe == 0, "R9 output enable during write", v_oe, 0);
        chk(v_addr == 0, "R10 address change under write strobe", v_addr, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule